// File: doc/BRIEF.md
# Two-Pulse Clutter Canceller

This block removes stationary returns from a stream of complex range-bin samples before they reach Doppler processing. Samples arrive one chirp at a time. Each sample carries signed I and Q parts, its range-bin index, and a marker that flags the first bin of a chirp. For every bin, the block subtracts the value that the same bin held in the previous chirp. It then clamps the result to the sample width and forwards it. Returns that do not move between chirps therefore cancel.

One chirp of history sits in an internal line memory with one word per range bin. Each word holds I and Q. The word for a bin is read out and then replaced with the current sample in the same accepted cycle. A frame-start pulse marks the next chirp as the first of a new frame. Every bin of that chirp comes out as zero, because it has nothing valid to subtract. The enable input is latched together with each sample. When it is low, that sample passes through untouched. The history memory and the chirp tracking keep updating whatever the enable setting, so re-enabling the block inside a frame subtracts against the chirp that went through in bypass.

Flow control is valid/ready on both sides and the pipeline has two register stages. While the output is held, the whole pipeline freezes and the input is not accepted.

Top module: `mti_canceller`

## Requirements
- R1: For an enabled sample that is not muted, out_i equals in_i minus the in_i of the same bin in the previously accepted chirp. The same rule applies to Q, computed independently.
- R2: Each difference is formed one bit wider than the sample and then clamped to the signed range -32768 to +32767 (for the default 16-bit width). A difference above the range gives +32767 and one below it gives -32768, never a wrapped value.
- R3: The first chirp accepted after reset produces zero on both I and Q for every one of its bins, as long as enable is high.
- R4: A frame_start pulse in the same cycle as an accepted sample that has in_first high makes that chirp the first of a frame, so all its bins are zero. A frame_start pulse on any other cycle leaves the chirp in progress as it was, and makes the next chirp that starts (in_first high) the muted first chirp.
- R5: A sample accepted while enable is low leaves with out_i and out_q equal to its in_i and in_q, even in a chirp that would otherwise be muted. Enable is sampled per sample, in the cycle the sample is accepted.
- R6: The history memory and the first-chirp tracking update on every accepted sample whatever the enable value. A chirp that passed in bypass is therefore the subtrahend for the next enabled chirp.
- R7: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_valid, out_i, out_q, out_bin and out_first hold their values into the next cycle.
- R8: Every accepted sample yields exactly one output, in acceptance order, carrying its own bin index and first marker. With the pipeline empty and out_ready high, a sample accepted on clock edge k is presented on the outputs after edge k+1.
- R9: While reset is asserted (rst_n low, asynchronous), out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 = cancel, 0 = pass the sample through; sampled with each accepted sample |
| frame_start | input | 1 | Single-cycle pulse that makes the next chirp the first of a frame |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_i | input | DATA_W | Signed in-phase part |
| in_q | input | DATA_W | Signed quadrature part |
| in_bin | input | clog2(NUM_BINS) | Range-bin index of the sample |
| in_first | input | 1 | High on the first bin of a chirp |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample |
| out_i | output | DATA_W | Signed in-phase result |
| out_q | output | DATA_W | Signed quadrature result |
| out_bin | output | clog2(NUM_BINS) | Range-bin index carried along with the sample |
| out_first | output | 1 | First-bin marker carried along with the sample |

## Verification
Two events can fall in the same cycle. The first case is a frame_start pulse arriving in the very cycle that the first bin of a new chirp is accepted, while a frame is already running. The bench provokes this by raising frame_start on the first cycle that bin 0 of every fourth chirp is presented. At full throughput this lands on the accepting edge; under random valid and ready it sometimes arrives alone a cycle early. The whole chirp must then come out as zeros, and each bin is judged against a model that applies the frame-start and first-marker rules in the order stated in R4. The second case is a sample with enable low landing inside a chirp that would otherwise be muted. That sample must still appear unchanged, while the history it writes must serve as the subtrahend for the next chirp.

// File: rtl/mti_canceller.sv
module mti_canceller #(
  parameter int DATA_W   = 16,
  parameter int NUM_BINS = 512,
  localparam int BIN_W   = $clog2(NUM_BINS),
  localparam int WORD_W  = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     frame_start,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic [BIN_W-1:0]         in_bin,
  input  logic                     in_first,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q,
  output logic [BIN_W-1:0]         out_bin,
  output logic                     out_first
);

  localparam logic signed [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic signed [DATA_W-1:0] sat_sub(
    input logic signed [DATA_W-1:0] a,
    input logic signed [DATA_W-1:0] b
  );
    logic [DATA_W:0] d;
    d = {a[DATA_W-1], a} - {b[DATA_W-1], b};
    if (d[DATA_W] != d[DATA_W-1]) return d[DATA_W] ? SMIN : SMAX;
    return d[DATA_W-1:0];
  endfunction

  logic advance, take;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign take     = in_valid && advance;

  logic [WORD_W-1:0] hist [NUM_BINS];
  logic [WORD_W-1:0] hist_rd;

  always_ff @(posedge clk) begin
    if (advance) begin
      hist_rd <= hist[in_bin];
      if (in_valid) hist[in_bin] <= {in_i, in_q};
    end
  end

  logic seen, chirp_muted, mute_now;
  assign mute_now = in_first ? (!seen || frame_start) : chirp_muted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen        <= 1'b0;
      chirp_muted <= 1'b1;
    end else if (take && in_first) begin
      seen        <= 1'b1;
      chirp_muted <= mute_now;
    end else if (frame_start) begin
      seen        <= 1'b0;
    end
  end

  logic                     s1_valid, s1_first, s1_en, s1_mute;
  logic signed [DATA_W-1:0] s1_i, s1_q;
  logic [BIN_W-1:0]         s1_bin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       s1_valid <= 1'b0;
    else if (advance) s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      s1_i     <= in_i;
      s1_q     <= in_q;
      s1_bin   <= in_bin;
      s1_first <= in_first;
      s1_en    <= enable;
      s1_mute  <= mute_now;
    end
  end

  logic signed [DATA_W-1:0] res_i, res_q;
  assign res_i = !s1_en ? s1_i : s1_mute ? '0 : sat_sub(s1_i, hist_rd[WORD_W-1:DATA_W]);
  assign res_q = !s1_en ? s1_q : s1_mute ? '0 : sat_sub(s1_q, hist_rd[DATA_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_valid <= 1'b0;
    else if (advance) out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (advance && s1_valid) begin
      out_i     <= res_i;
      out_q     <= res_q;
      out_bin   <= s1_bin;
      out_first <= s1_first;
    end
  end

endmodule

// File: rtl/mti_canceller_chk.sv
module mti_canceller_chk #(
  parameter int DATA_W   = 16,
  parameter int NUM_BINS = 512,
  localparam int BIN_W   = $clog2(NUM_BINS)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     enable,
  input logic                     frame_start,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic signed [DATA_W-1:0] in_i,
  input logic signed [DATA_W-1:0] in_q,
  input logic [BIN_W-1:0]         in_bin,
  input logic                     in_first,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [DATA_W-1:0] out_i,
  input logic signed [DATA_W-1:0] out_q,
  input logic [BIN_W-1:0]         out_bin,
  input logic                     out_first
);

  logic c_seen, c_muted, c_mute;
  logic sa_v, sa_first, sa_en, sa_mute, sb_v, sb_first, sb_en, sb_mute;
  logic signed [DATA_W-1:0] sa_i, sa_q, sb_i, sb_q;
  logic [BIN_W-1:0] sa_bin, sb_bin;

  always_comb begin
    if (in_first) c_mute = frame_start || !c_seen;
    else          c_mute = c_muted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_seen <= 1'b0; c_muted <= 1'b1; sa_v <= 1'b0; sb_v <= 1'b0;
    end else begin
      if (in_valid && in_ready && in_first) begin
        c_seen <= 1'b1; c_muted <= c_mute;
      end else if (frame_start) c_seen <= 1'b0;
      if (in_ready) begin
        sa_v <= in_valid; sb_v <= sa_v;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready) begin
      sa_i <= in_i; sa_q <= in_q; sa_bin <= in_bin; sa_first <= in_first;
      sa_en <= enable; sa_mute <= c_mute;
      sb_i <= sa_i; sb_q <= sa_q; sb_bin <= sa_bin; sb_first <= sa_first;
      sb_en <= sa_en; sb_mute <= sa_mute;
    end
  end

  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !sb_en |-> out_i == sb_i && out_q == sb_q);

  p_first_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && sb_en && sb_mute |-> out_i == '0 && out_q == '0);

  p_tags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sb_v && out_bin == sb_bin && out_first == sb_first);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q)
      && $stable(out_bin) && $stable(out_first));

  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

bind mti_canceller mti_canceller_chk #(.DATA_W(DATA_W), .NUM_BINS(NUM_BINS)) u_chk (.*);

// File: tb/mti_canceller_tb_top.sv
module mti_canceller_tb_top;
  localparam int DW = 16, NB = 16, BW = $clog2(NB), CPF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic enable = 1'b1, frame_start = 1'b0, in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b1;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic [BW-1:0] in_bin = '0;
  logic in_ready, out_valid, out_first;
  logic signed [DW-1:0] out_i, out_q;
  logic [BW-1:0] out_bin;

  mti_canceller #(.DATA_W(DW), .NUM_BINS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .in_bin(in_bin), .in_first(in_first), .out_valid(out_valid),
    .out_ready(out_ready), .out_i(out_i), .out_q(out_q), .out_bin(out_bin),
    .out_first(out_first));

  typedef struct packed {
    logic signed [DW-1:0] i;
    logic signed [DW-1:0] q;
    logic [BW-1:0] bin;
    logic first;
    logic [3:0] tag;
  } exp_t;
  exp_t exq[$];

  int checks = 0, failures = 0;
  bit done = 1'b0;

  int hist_i [NB], hist_q [NB];
  bit hist_byp [NB];
  bit m_seen = 1'b0, m_muted = 1'b1, m_coinc = 1'b0, m_clr_fs = 1'b0;

  int g_bin = 0, g_chirp = 0, g_i = 0, g_q = 0;
  bit g_need = 1'b1, g_en = 1'b1, g_fs = 1'b0;
  int pv = 100, pr = 100, en_mode = 0, dmode = 0, pfs = 0;

  bit ps_stall = 1'b0;
  logic signed [DW-1:0] ps_i, ps_q;
  logic [BW-1:0] ps_bin;

  task automatic chk(input bit ok, input int req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int rnd16();
    logic signed [DW-1:0] t;
    t = DW'($urandom);
    return int'(t);
  endfunction

  task automatic prepare();
    g_fs = (g_bin == 0) && (g_chirp % CPF == 0);
    case (dmode)
      0: begin g_i = rnd16(); g_q = rnd16(); end
      1: begin g_i = int'($urandom_range(0, 200)) - 100; g_q = int'($urandom_range(0, 200)) - 100; end
      default: begin
        g_i = (g_chirp % 2 == 0) ? -32768 : 32767;
        g_q = (g_chirp % 2 == 0) ? 32767 : -32768;
      end
    endcase
    case (en_mode)
      0: g_en = 1'b1;
      1: g_en = 1'b0;
      2: g_en = 1'($urandom % 2);
      default: g_en = (g_chirp % 2 == 0);
    endcase
    g_need = 1'b0;
  endtask

  // One clock: drive at the falling edge, then score what the next rising edge will do.
  task automatic step(input int fv, input int fr);
    exp_t e;
    bit mute, coinc;
    int di, dq;
    @(negedge clk);
    if (ps_stall)  // R7 hold under backpressure
      chk(out_valid && out_i == ps_i && out_q == ps_q && out_bin == ps_bin, 7,
          "stalled output changed", out_i, ps_i);
    if (g_need) prepare();
    in_valid    = (fv < 0) ? (int'($urandom % 100) < pv) : (fv != 0);
    out_ready   = (fr < 0) ? (int'($urandom % 100) < pr) : (fr != 0);
    frame_start = g_fs || (int'($urandom % 1000) < pfs);
    g_fs        = 1'b0;
    in_i = DW'(g_i); in_q = DW'(g_q); in_bin = BW'(g_bin);
    in_first = (g_bin == 0); enable = g_en;
    #1;
    chk(in_ready == (!out_valid || out_ready), 7, "in_ready", in_ready, !out_valid || out_ready);
    if (out_valid && out_ready) begin
      if (exq.size() == 0) chk(1'b0, 8, "unexpected output", 1, 0);
      else begin
        e = exq.pop_front();
        chk(out_i == e.i && out_q == e.q, int'(e.tag), "data (I shown)", out_i, e.i);
        chk(out_bin == e.bin && out_first == e.first, 8, "bin/first tag", out_bin, e.bin);
      end
    end
    if (in_valid && in_ready) begin
      mute  = in_first ? (!m_seen || frame_start) : m_muted;
      coinc = in_first ? ((frame_start && m_seen) || (!m_seen && m_clr_fs)) : m_coinc;
      e.bin = in_bin; e.first = in_first;
      if (!enable) begin
        e.i = in_i; e.q = in_q; e.tag = 4'd5;               // R5 pass-through
      end else if (mute) begin
        e.i = '0; e.q = '0; e.tag = coinc ? 4'd4 : 4'd3;    // R4 / R3 muted chirp
      end else begin
        di = int'(in_i) - hist_i[g_bin];
        dq = int'(in_q) - hist_q[g_bin];
        e.i = DW'(sat16(di)); e.q = DW'(sat16(dq));
        if (sat16(di) != di || sat16(dq) != dq) e.tag = 4'd2; // R2 clamp
        else if (hist_byp[g_bin]) e.tag = 4'd6;              // R6 bypassed history
        else e.tag = 4'd1;                                   // R1 plain difference
      end
      exq.push_back(e);
      hist_i[g_bin] = int'(in_i); hist_q[g_bin] = int'(in_q); hist_byp[g_bin] = !enable;
      if (in_first) begin
        m_muted = mute; m_coinc = coinc; m_seen = 1'b1; m_clr_fs = 1'b0;
      end else if (frame_start) begin
        m_seen = 1'b0; m_clr_fs = 1'b1;
      end
      g_bin++;
      if (g_bin == NB) begin g_bin = 0; g_chirp++; end
      g_need = 1'b1;
    end else if (frame_start) begin
      m_seen = 1'b0; m_clr_fs = 1'b1;
    end
    ps_stall = out_valid && !out_ready;
    ps_i = out_i; ps_q = out_q; ps_bin = out_bin;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin hist_i[b] = 0; hist_q[b] = 0; hist_byp[b] = 1'b0; end
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, 9, "out_valid in reset", out_valid, 0);  // R9
    chk(in_ready == 1'b1, 9, "in_ready in reset", in_ready, 1);     // R9
    rst_n = 1'b1;

    // R8 latency and R3 first chirp after reset
    dmode = 1; en_mode = 0;
    repeat (3) step(0, 1);
    step(1, 1);
    step(0, 1);
    chk(out_valid == 1'b0, 8, "latency: early output", out_valid, 0);
    step(0, 1);
    chk(out_valid == 1'b1, 8, "latency: output missing", out_valid, 1);
    while (g_bin != 0) step(1, 1);

    // R2 clamp in both directions, then R4 frame_start on an accepted first bin
    dmode = 2;
    for (int k = 0; k < 5 * NB; k++) step(1, 1);

    // Constrained random phases
    for (int ph = 0; ph < 12; ph++) begin
      pv = (ph % 3 == 0) ? 100 : (ph % 3 == 1) ? 70 : 35;
      pr = (ph % 4 == 0) ? 100 : (ph % 4 == 1) ? 40 : 75;
      en_mode = ph % 4;
      dmode = ph % 3;
      pfs = (ph >= 8) ? 6 : 0;
      for (int k = 0; k < 800; k++) step(-1, -1);
    end

    pfs = 0;
    repeat (10) step(0, 1);
    chk(exq.size() == 0, 8, "outputs outstanding", exq.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule